// File: doc/BRIEF.md
# Colour Standard Identification Scanner

This block is the field-rate controller of a multi-standard colour decoder. It searches for the colour standard of an incoming video signal by trying four candidates in turn, presenting each one as a one-hot standard select so that the analog filters, reference crystal and demodulator can follow. Two identification comparator flags (a PAL/SECAM flag with separate positive and negative indications, and an NTSC flag), a 60 Hz field-rate flag and single-cycle field and line strobes from the blanking pulse decoder feed it.

When the flags agree with the standard being tried, the scanner stops and enables colour after a short delay counted in field strobes, so colour only switches during field blanking. A brief loss of identification turns colour off at once and holds the standard for a few fields before the search starts again. A forced-standard input overrides the search. The block also keeps the H/2 (half line rate) phase flip-flop used to rectify the line-alternating identification result. All timing is counted in field strobes; `DWELL_FIELDS`, `ON_FIELDS` and `HOLD_FIELDS` set the windows.

Top module: `colour_std_scan`

## Requirements
- R1: The standard select is one-hot with bit 0 = PAL, bit 1 = SECAM, bit 2 = NTSC 3.58 MHz, bit 3 = NTSC 4.43 MHz; an unidentified search visits them in the order bit 0, 1, 2, 3 and then wraps to bit 0.
- R2: Each standard is tried for exactly `DWELL_FIELDS` (default 4) field strobes without a match; the select changes on the last of them and never between field strobes.
- R3: A match is sampled at a field strobe: in PAL mode the PAL/SECAM flag is positive; in SECAM mode that flag is positive and the 60 Hz flag is low; in NTSC 3.58 mode the NTSC flag is positive; in NTSC 4.43 mode the NTSC flag is positive and the PAL/SECAM flag is not. A match while searching stops the search (scanning output goes low) at that strobe.
- R4: A positive PAL/SECAM flag in SECAM mode while searching sends the select back to PAL, still scanning; at the next field strobe a positive flag identifies PAL, otherwise SECAM is selected and identified.
- R5: With the 60 Hz flag high, a positive PAL/SECAM flag in SECAM mode never identifies SECAM; the select moves to NTSC 3.58 at that strobe, still scanning.
- R6: Colour enable rises at the `ON_FIELDS`-th (default 2) matching field strobe after the identifying strobe and, outside a force, changes only at a field strobe.
- R7: While identified, a field strobe without a match clears colour enable at that strobe; after `HOLD_FIELDS` (default 2) consecutive misses the search restarts at PAL with scanning high; a match before then keeps the standard and restarts the colour delay.
- R8: The H/2 phase output toggles at every line strobe, except that a line strobe with the negative PAL/SECAM indication leaves it unchanged, shifting it to the opposite phase.
- R9: A non-zero force input selects, from the next clock and without waiting for a field strobe, the standard of its lowest set bit (same bit order as R1), with scanning low and colour enable high, ignoring the flags; when the force returns to zero the search restarts at PAL with colour off.
- R10: After reset the select is PAL (0001), scanning is high, colour enable and the H/2 phase are low.
- R11: Colour enable is never high while scanning is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_stb | input | 1 | One-cycle strobe per field, during field blanking |
| line_stb | input | 1 | One-cycle strobe per line |
| id_ps_pos | input | 1 | PAL/SECAM identification flag positive |
| id_ps_neg | input | 1 | PAL/SECAM identification flag negative (wrong H/2 phase) |
| id_nt_pos | input | 1 | NTSC identification flag positive |
| rate_60hz | input | 1 | Field rate is 60 Hz |
| force_std | input | 4 | Forced standard request, one bit per standard as in R1 |
| std_sel | output | 4 | One-hot standard select |
| scanning | output | 1 | High while searching, low when identified or forced |
| colour_en | output | 1 | Colour on |
| h2_phase | output | 1 | H/2 phase flip-flop |

## Verification
The bench walks the full search loop strobe by strobe, so a dwell counter off by one shows as a select change one field early or late. It drives a SECAM-mode positive flag with and without the 60 Hz flag and with both outcomes of the PAL recheck; a design without PAL priority would lock SECAM at once, and one without the lockout would identify SECAM on a 60 Hz signal. It presents both identification flags in NTSC 4.43 mode, where a design that ignores the PAL/SECAM flag would wrongly identify a PAL signal, and it drops the match for one and for two fields to separate hold from restart. Forces with two bits set and force release check the lowest-index choice and the return to PAL.

// File: rtl/cstd_pkg.sv
package cstd_pkg;

    typedef enum logic [1:0] {
        STD_PAL   = 2'd0,
        STD_SECAM = 2'd1,
        STD_NT358 = 2'd2,
        STD_NT443 = 2'd3
    } std_e;

    localparam int NUM_STD = 4;

    typedef struct packed {
        logic ps_pos;
        logic ps_neg;
        logic nt_pos;
        logic r60;
    } id_flags_t;

    function automatic logic [NUM_STD-1:0] std_onehot(input std_e s);
        logic [NUM_STD-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic std_e std_next(input std_e s);
        return std_e'(s + 2'd1);
    endfunction

    function automatic std_e lowest_forced(input logic [NUM_STD-1:0] f);
        std_e r;
        r = STD_PAL;
        for (int i = NUM_STD - 1; i >= 0; i--) begin
            if (f[i]) r = std_e'(i);
        end
        return r;
    endfunction

    function automatic logic std_match(input std_e s, input id_flags_t f);
        case (s)
            STD_PAL:   return f.ps_pos;
            STD_SECAM: return f.ps_pos && !f.r60;
            STD_NT358: return f.nt_pos;
            default:   return f.nt_pos && !f.ps_pos;
        endcase
    endfunction

endpackage

// File: rtl/cs_field_cnt.sv
module cs_field_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + W'(1);
    end

    p_cnt_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt != '1) |=> (cnt == $past(cnt) + W'(1)));

endmodule

// File: rtl/cs_h2_flop.sv
module cs_h2_flop (
    input  logic clk,
    input  logic rst,
    input  logic line_stb,
    input  logic wrong_phase,
    output logic h2
);

    always_ff @(posedge clk) begin
        if (rst)                         h2 <= 1'b0;
        else if (line_stb && !wrong_phase) h2 <= ~h2;
    end

    p_h2_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !wrong_phase) |=> (h2 != $past(h2)));

    p_h2_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!line_stb || wrong_phase) |=> $stable(h2));

endmodule

// File: rtl/colour_std_scan.sv
module colour_std_scan #(
    parameter int DWELL_FIELDS = 4,
    parameter int ON_FIELDS    = 2,
    parameter int HOLD_FIELDS  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       field_stb,
    input  logic       line_stb,
    input  logic       id_ps_pos,
    input  logic       id_ps_neg,
    input  logic       id_nt_pos,
    input  logic       rate_60hz,
    input  logic [3:0] force_std,
    output logic [3:0] std_sel,
    output logic       scanning,
    output logic       colour_en,
    output logic       h2_phase
);
    import cstd_pkg::*;

    localparam int CMAX = (DWELL_FIELDS > ON_FIELDS)
                        ? ((DWELL_FIELDS > HOLD_FIELDS) ? DWELL_FIELDS : HOLD_FIELDS)
                        : ((ON_FIELDS > HOLD_FIELDS) ? ON_FIELDS : HOLD_FIELDS);
    localparam int CW = $clog2(CMAX + 1);
    localparam logic [CW-1:0] DWELL_LAST = CW'(DWELL_FIELDS - 1);
    localparam logic [CW-1:0] ON_LAST    = CW'(ON_FIELDS - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_FIELDS - 1);

    std_e      mode_q, mode_n;
    logic      locked_q, locked_n;
    logic      colour_q, colour_n;
    logic      palchk_q, palchk_n;
    logic      forced_q;
    id_flags_t flags;
    logic      match;
    logic      force_any;

    logic [CW-1:0] scan_cnt, on_cnt, miss_cnt;
    logic scan_clr, scan_inc, on_clr, on_inc, miss_clr, miss_inc;

    assign flags     = '{ps_pos: id_ps_pos, ps_neg: id_ps_neg,
                         nt_pos: id_nt_pos, r60: rate_60hz};
    assign match     = std_match(mode_q, flags);
    assign force_any = |force_std;

    always_comb begin
        mode_n   = mode_q;
        locked_n = locked_q;
        colour_n = colour_q;
        palchk_n = palchk_q;
        scan_clr = 1'b0; scan_inc = 1'b0;
        on_clr   = 1'b0; on_inc   = 1'b0;
        miss_clr = 1'b0; miss_inc = 1'b0;
        if (force_any) begin
            mode_n   = lowest_forced(force_std);
            locked_n = 1'b1;
            colour_n = 1'b1;
            palchk_n = 1'b0;
            scan_clr = 1'b1; on_clr = 1'b1; miss_clr = 1'b1;
        end else if (forced_q) begin
            mode_n   = STD_PAL;
            locked_n = 1'b0;
            colour_n = 1'b0;
            palchk_n = 1'b0;
            scan_clr = 1'b1; on_clr = 1'b1; miss_clr = 1'b1;
        end else if (field_stb) begin
            if (!locked_q) begin
                if (palchk_q) begin
                    palchk_n = 1'b0;
                    locked_n = 1'b1;
                    scan_clr = 1'b1; on_clr = 1'b1; miss_clr = 1'b1;
                    if (!flags.ps_pos) mode_n = STD_SECAM;
                end else if (mode_q == STD_SECAM && flags.ps_pos && flags.r60) begin
                    mode_n   = STD_NT358;
                    scan_clr = 1'b1;
                end else if (mode_q == STD_SECAM && flags.ps_pos) begin
                    mode_n   = STD_PAL;
                    palchk_n = 1'b1;
                    scan_clr = 1'b1;
                end else if (match) begin
                    locked_n = 1'b1;
                    scan_clr = 1'b1; on_clr = 1'b1; miss_clr = 1'b1;
                end else if (scan_cnt == DWELL_LAST) begin
                    mode_n   = std_next(mode_q);
                    scan_clr = 1'b1;
                end else begin
                    scan_inc = 1'b1;
                end
            end else begin
                if (match) begin
                    miss_clr = 1'b1;
                    if (on_cnt == ON_LAST) colour_n = 1'b1;
                    else                   on_inc   = 1'b1;
                end else begin
                    colour_n = 1'b0;
                    on_clr   = 1'b1;
                    if (miss_cnt == HOLD_LAST) begin
                        locked_n = 1'b0;
                        mode_n   = STD_PAL;
                        scan_clr = 1'b1; miss_clr = 1'b1;
                    end else begin
                        miss_inc = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= STD_PAL;
            locked_q <= 1'b0;
            colour_q <= 1'b0;
            palchk_q <= 1'b0;
            forced_q <= 1'b0;
        end else begin
            mode_q   <= mode_n;
            locked_q <= locked_n;
            colour_q <= colour_n;
            palchk_q <= palchk_n;
            forced_q <= force_any;
        end
    end

    cs_field_cnt #(.W(CW)) u_scan_cnt (
        .clk(clk), .rst(rst), .clr(scan_clr), .inc(scan_inc), .cnt(scan_cnt));
    cs_field_cnt #(.W(CW)) u_on_cnt (
        .clk(clk), .rst(rst), .clr(on_clr), .inc(on_inc), .cnt(on_cnt));
    cs_field_cnt #(.W(CW)) u_miss_cnt (
        .clk(clk), .rst(rst), .clr(miss_clr), .inc(miss_inc), .cnt(miss_cnt));

    cs_h2_flop u_h2 (
        .clk(clk), .rst(rst), .line_stb(line_stb),
        .wrong_phase(id_ps_neg), .h2(h2_phase));

    assign std_sel   = std_onehot(mode_q);
    assign scanning  = !locked_q;
    assign colour_en = colour_q;

    p_sel_field_only_r2: assert property (@(posedge clk) disable iff (rst)
        (!field_stb && !force_any && !forced_q) |=> $stable(std_sel));

    p_colour_field_only_r6: assert property (@(posedge clk) disable iff (rst)
        (!field_stb && !force_any && !forced_q) |=> $stable(colour_en));

    p_colour_needs_id_r11: assert property (@(posedge clk) disable iff (rst)
        colour_en |-> !scanning);

    p_sixty_lockout_r5: assert property (@(posedge clk) disable iff (rst)
        (field_stb && scanning && !palchk_q && std_sel == 4'b0010 && id_ps_pos
         && rate_60hz && !force_any && !forced_q) |=> (std_sel == 4'b0100 && scanning));

    p_force_wins_r9: assert property (@(posedge clk) disable iff (rst)
        force_any |=> (!scanning && colour_en));

    p_dwell_bound_r2: assert property (@(posedge clk) disable iff (rst)
        scanning |-> (scan_cnt <= DWELL_LAST));

endmodule

// File: tb/tb_colour_std_scan.sv
module tb_colour_std_scan;

    logic       clk = 1'b0;
    logic       rst;
    logic       field_stb, line_stb;
    logic       id_ps_pos, id_ps_neg, id_nt_pos, rate_60hz;
    logic [3:0] force_std;
    logic [3:0] std_sel;
    logic       scanning, colour_en, h2_phase;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    colour_std_scan dut (
        .clk(clk), .rst(rst), .field_stb(field_stb), .line_stb(line_stb),
        .id_ps_pos(id_ps_pos), .id_ps_neg(id_ps_neg), .id_nt_pos(id_nt_pos),
        .rate_60hz(rate_60hz), .force_std(force_std), .std_sel(std_sel),
        .scanning(scanning), .colour_en(colour_en), .h2_phase(h2_phase));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [3:0] sel,
                             input logic sc, input logic col);
        chk(req, std_sel, sel);
        chk(req, {3'b0, scanning}, {3'b0, sc});
        chk(req, {3'b0, colour_en}, {3'b0, col});
    endtask

    task automatic set_flags(input logic ps, input logic nt, input logic r60);
        @(negedge clk);
        id_ps_pos = ps; id_nt_pos = nt; rate_60hz = r60;
    endtask

    task automatic fld(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); field_stb = 1'b1;
            @(negedge clk); field_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; field_stb = 1'b0; line_stb = 1'b0;
        id_ps_pos = 1'b0; id_ps_neg = 1'b0; id_nt_pos = 1'b0; rate_60hz = 1'b0;
        force_std = 4'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk_state("R10", 4'b0001, 1'b1, 1'b0);
        chk("R10", {3'b0, h2_phase}, 4'b0);
    endtask

    task automatic t_scan_order();
        do_reset();
        fld(3);
        chk_state("R2", 4'b0001, 1'b1, 1'b0);
        fld(1);
        chk_state("R1", 4'b0010, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk("R2", std_sel, 4'b0010);
        fld(4);
        chk_state("R1", 4'b0100, 1'b1, 1'b0);
        fld(4);
        chk_state("R1", 4'b1000, 1'b1, 1'b0);
        fld(4);
        chk_state("R1", 4'b0001, 1'b1, 1'b0);
    endtask

    task automatic t_pal_id();
        do_reset();
        set_flags(1'b1, 1'b0, 1'b0);
        fld(1);
        chk_state("R3", 4'b0001, 1'b0, 1'b0);
        fld(1);
        chk_state("R6", 4'b0001, 1'b0, 1'b0);
        fld(1);
        chk_state("R6", 4'b0001, 1'b0, 1'b1);
        chk("R11", {3'b0, colour_en & scanning}, 4'b0);
    endtask

    task automatic t_pal_priority();
        do_reset();
        fld(4);
        set_flags(1'b1, 1'b0, 1'b0);
        fld(1);
        chk_state("R4", 4'b0001, 1'b1, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
        fld(1);
        chk_state("R4", 4'b0010, 1'b0, 1'b0);
        set_flags(1'b1, 1'b0, 1'b0);
        fld(2);
        chk_state("R6", 4'b0010, 1'b0, 1'b1);
        do_reset();
        fld(4);
        set_flags(1'b1, 1'b0, 1'b0);
        fld(1);
        fld(1);
        chk_state("R4", 4'b0001, 1'b0, 1'b0);
    endtask

    task automatic t_sixty();
        do_reset();
        fld(4);
        set_flags(1'b1, 1'b0, 1'b1);
        fld(1);
        chk_state("R5", 4'b0100, 1'b1, 1'b0);
    endtask

    task automatic t_ntsc();
        do_reset();
        fld(12);
        set_flags(1'b1, 1'b1, 1'b0);
        fld(1);
        chk_state("R3", 4'b1000, 1'b1, 1'b0);
        set_flags(1'b0, 1'b1, 1'b0);
        fld(1);
        chk_state("R3", 4'b1000, 1'b0, 1'b0);
        do_reset();
        fld(8);
        set_flags(1'b0, 1'b1, 1'b0);
        fld(1);
        chk_state("R3", 4'b0100, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        do_reset();
        set_flags(1'b1, 1'b0, 1'b0);
        fld(3);
        set_flags(1'b0, 1'b0, 1'b0);
        fld(1);
        chk_state("R7", 4'b0001, 1'b0, 1'b0);
        set_flags(1'b1, 1'b0, 1'b0);
        fld(1);
        chk_state("R7", 4'b0001, 1'b0, 1'b0);
        fld(1);
        chk_state("R7", 4'b0001, 1'b0, 1'b1);
        set_flags(1'b0, 1'b0, 1'b0);
        fld(1);
        chk_state("R7", 4'b0001, 1'b0, 1'b0);
        fld(1);
        chk_state("R7", 4'b0001, 1'b1, 1'b0);
        fld(4);
        chk("R7", std_sel, 4'b0010);
    endtask

    task automatic t_force();
        do_reset();
        @(negedge clk); force_std = 4'b1010;
        @(negedge clk);
        chk_state("R9", 4'b0010, 1'b0, 1'b1);
        set_flags(1'b0, 1'b1, 1'b1);
        fld(3);
        chk_state("R9", 4'b0010, 1'b0, 1'b1);
        @(negedge clk); force_std = 4'b1000;
        @(negedge clk);
        chk_state("R9", 4'b1000, 1'b0, 1'b1);
        set_flags(1'b0, 1'b0, 1'b0);
        @(negedge clk); force_std = 4'b0000;
        @(negedge clk);
        chk_state("R9", 4'b0001, 1'b1, 1'b0);
        fld(4);
        chk("R9", std_sel, 4'b0010);
    endtask

    task automatic t_h2();
        logic exp_h2;
        do_reset();
        exp_h2 = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); line_stb = 1'b1;
            @(negedge clk); line_stb = 1'b0;
            exp_h2 = ~exp_h2;
            chk("R8", {3'b0, h2_phase}, {3'b0, exp_h2});
        end
        @(negedge clk); line_stb = 1'b1; id_ps_neg = 1'b1;
        @(negedge clk); line_stb = 1'b0; id_ps_neg = 1'b0;
        chk("R8", {3'b0, h2_phase}, {3'b0, exp_h2});
        @(negedge clk); line_stb = 1'b1;
        @(negedge clk); line_stb = 1'b0;
        exp_h2 = ~exp_h2;
        chk("R8", {3'b0, h2_phase}, {3'b0, exp_h2});
    endtask

    initial begin
        rst = 1'b1; field_stb = 1'b0; line_stb = 1'b0;
        id_ps_pos = 1'b0; id_ps_neg = 1'b0; id_nt_pos = 1'b0; rate_60hz = 1'b0;
        force_std = 4'b0;
        t_reset();
        t_scan_order();
        t_pal_id();
        t_pal_priority();
        t_sixty();
        t_ntsc();
        t_hold();
        t_force();
        t_h2();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule